// File: doc/BRIEF.md
# Banked Flash Window with Memory-Mapped SD Card Port

This block decodes one subslot of an 8-bit CPU's memory space. The range 4000h–BFFFh is split into four 8 KB pages. Each page is steered by an 8-bit bank register into a 1 MB region that sits at the top of an 8 MB flash, 700000h–7FFFFFh. The CPU reloads the four bank registers by writing into 6000h–7FFFh. Outside the window, reads return FFh.

Page 0 can also carry a card port. When its bank register holds 01b in bits 7:6, 4000h–5FFFh stops showing flash and becomes a small register area for two SD cards wired in SPI mode.

In that area, one CPU access moves one byte. A write sends its data byte on MOSI. A read sends FFh and returns the byte captured by the previous transfer. The address of the access sets the chip-select level that the selected card sees. An access in 4000h–4FFFh asserts chip select. An access in 5000h–5FFFh releases it. A write in 5800h–5FFFh picks which of the two cards is addressed. The card command protocol and the flash device itself sit outside the block.

Top module: `card_flash_window`

## Requirements
- R1: After a synchronous reset, the bank registers of pages 0..3 hold 00h, 01h, 00h, 00h. The card select is 0, both chip selects are high, SCLK is low, MOSI is high, busy is low, and the captured receive byte is FFh.
- R2: A CPU write to 6000h–7FFFh loads bank register addr[12:11] with the write data. The flash write strobe for that same access uses the bank value in force before the load.
- R3: For an access in 4000h–BFFFh outside the card area, the page is (addr−4000h)>>13 and flash_addr = 700000h + (bank[6:0] × 2000h) + addr[12:0]. flash_we pulses for writes, flash_re pulses for reads, and cpu_rdata returns flash_rdata.
- R4: Reads below 4000h or at C000h and above return FFh and raise no flash strobe.
- R5: The card area is 4000h–5FFFh, and it exists only while page-0 bank bits 7:6 equal 01b. Accesses there raise no flash strobe and never change a bank register.
- R6: A transfer started from 4000h–4FFFh drives the selected card's chip select low (level 0). A transfer started from 5000h–5FFFh drives it high (level 1), and this includes reads in 5800h–5FFFh. The level holds after the transfer ends.
- R7: A write in 5800h–5FFFh of the card area sets the card select to data bit 0 (0 = first card on spi_cs_n[0], 1 = second card on spi_cs_n[1]) and starts no transfer.
- R8: A transfer uses SPI mode 0, MSB first. SCLK idles low. Each SCLK half period lasts HALF_DIV clocks. A write shifts out its data byte, a read shifts out FFh, and busy stays high for exactly 16 × HALF_DIV clocks.
- R9: The byte captured from MISO at the end of a transfer is what a later read in the card area returns. Until the first transfer ends, that value is FFh.
- R10: While busy is high, accesses to the card area are ignored. They start no transfer and leave the card select unchanged.
- R11: The chip select of the card that is not selected is held high. The two chip selects are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data (combinational) |
| flash_addr | output | 23 | Flash byte address |
| flash_we | output | 1 | Flash write strobe |
| flash_re | output | 1 | Flash read strobe |
| flash_wdata | output | 8 | Flash write data |
| flash_rdata | input | 8 | Flash read data |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data to the card |
| spi_miso | input | 1 | SPI data from the card |
| spi_cs_n | output | 2 | Active-low chip selects, one per card |
| busy | output | 1 | A byte transfer is in progress |

## Verification
The bench targets five corner cases.

- A write to a bank register must reach flash through the old bank. A design that updated the bank first would write the byte into the wrong 8 KB sector.
- Writes issued while a transfer is running must be dropped. A design that accepted them would restart the shifter or move the chip select in the middle of a byte, and the per-cycle SCLK, MOSI and chip-select comparison would flag it.
- A read in the card area must return the previously captured byte. A design that returned the live shift register, or skipped the capture on write transfers, would show the wrong read data.
- Switching cards must move the held chip-select level to the other card. A design that got this wrong would leave both cards selected or neither.
- Turning the card area off must bring flash back at 4000h. A design that left it on would keep the flash strobes missing there.

// File: rtl/cfw_pkg.sv
package cfw_pkg;

    localparam int CPU_AW    = 16;
    localparam int BYTE_W    = 8;
    localparam int FLASH_AW  = 23;
    localparam int NUM_PAGES = 4;
    localparam int NUM_CARDS = 2;
    localparam int PAGE_OFS_W = 13;
    localparam int BANK_USE_W = FLASH_AW - PAGE_OFS_W - 3;

    localparam logic [2:0] REGION_TOP  = 3'b111;
    localparam logic [1:0] CARD_MODE   = 2'b01;
    localparam logic [7:0] IDLE_BYTE   = 8'hFF;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [1:0]        page_t;

    typedef enum logic {
        SPI_IDLE  = 1'b0,
        SPI_SHIFT = 1'b1
    } spi_state_e;

    typedef struct packed {
        logic  in_window;
        logic  card_area;
        page_t page;
        logic  bank_load;
        logic  sel_load;
        logic  xfer;
        logic  cs_level;
    } dec_t;

    function automatic byte_t bank_reset_value(input int idx);
        return (idx == 1) ? byte_t'(1) : byte_t'(0);
    endfunction

    function automatic logic [FLASH_AW-1:0] map_flash(input byte_t bank,
                                                      input logic [CPU_AW-1:0] addr);
        return {REGION_TOP, bank[BANK_USE_W-1:0], addr[PAGE_OFS_W-1:0]};
    endfunction

endpackage

// File: rtl/cfw_decode.sv
module cfw_decode
    import cfw_pkg::*;
(
    input  logic              req,
    input  logic              we,
    input  logic [CPU_AW-1:0] addr,
    input  byte_t             bank0,
    output dec_t              dec
);
    logic card_mode;
    logic in_card_range;

    always_comb begin
        card_mode     = (bank0[7:6] == CARD_MODE);
        in_card_range = (addr[15:13] == 3'b010);

        dec           = '0;
        dec.in_window = (addr[15:14] == 2'b01) || (addr[15:14] == 2'b10);
        dec.card_area = card_mode && in_card_range;
        dec.page      = addr[14:13] ^ 2'b10;
        dec.bank_load = req && we && (addr[15:13] == 3'b011);
        dec.sel_load  = req && we && dec.card_area && (addr[12:11] == 2'b11);
        dec.xfer      = req && dec.card_area && !dec.sel_load;
        dec.cs_level  = addr[12];
    end
endmodule

// File: rtl/cfw_bank_regs.sv
module cfw_bank_regs
    import cfw_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  page_t                      idx,
    input  byte_t                      wdata,
    output logic [NUM_PAGES-1:0][BYTE_W-1:0] banks
);
    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                banks[g] <= bank_reset_value(g);
            end else if (load && (idx == page_t'(g))) begin
                banks[g] <= wdata;
            end
        end
    end

    // R2
    bank_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (banks[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/cfw_spi_shifter.sv
module cfw_spi_shifter
    import cfw_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  byte_t tx,
    input  logic  miso,
    output logic  sclk,
    output logic  mosi,
    output logic  busy,
    output byte_t rx_byte
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    spi_state_e       state;
    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_cnt;
    byte_t            sh_out;
    byte_t            sh_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SPI_IDLE;
            div_cnt <= '0;
            bit_cnt <= '0;
            sh_out  <= IDLE_BYTE;
            sh_in   <= IDLE_BYTE;
            sclk    <= 1'b0;
            rx_byte <= IDLE_BYTE;
        end else if (state == SPI_IDLE) begin
            if (start) begin
                state   <= SPI_SHIFT;
                sh_out  <= tx;
                div_cnt <= '0;
                bit_cnt <= '0;
                sclk    <= 1'b0;
            end
        end else if (div_cnt == DIV_LAST) begin
            div_cnt <= '0;
            if (!sclk) begin
                sclk  <= 1'b1;
                sh_in <= {sh_in[BYTE_W-2:0], miso};
            end else begin
                sclk <= 1'b0;
                if (bit_cnt == 3'd7) begin
                    state   <= SPI_IDLE;
                    rx_byte <= sh_in;
                end else begin
                    bit_cnt <= bit_cnt + 3'd1;
                    sh_out  <= {sh_out[BYTE_W-2:0], 1'b0};
                end
            end
        end else begin
            div_cnt <= div_cnt + DIV_W'(1);
        end
    end

    assign busy = (state == SPI_SHIFT);
    assign mosi = busy ? sh_out[BYTE_W-1] : 1'b1;

    // R8
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);
    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
    // R10
    no_start_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
endmodule

// File: rtl/card_flash_window.sv
module card_flash_window
    import cfw_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [15:0]         cpu_addr,
    input  logic [7:0]          cpu_wdata,
    output logic [7:0]          cpu_rdata,
    output logic [22:0]         flash_addr,
    output logic                flash_we,
    output logic                flash_re,
    output logic [7:0]          flash_wdata,
    input  logic [7:0]          flash_rdata,
    output logic                spi_sclk,
    output logic                spi_mosi,
    input  logic                spi_miso,
    output logic [1:0]          spi_cs_n,
    output logic                busy
);
    logic [NUM_PAGES-1:0][BYTE_W-1:0] banks;
    dec_t  dec;
    logic  start_xfer;
    logic  sel_go;
    logic  card_sel;
    logic  cs_level_q;
    byte_t rx_byte;
    byte_t tx_byte;
    logic  flash_hit;

    cfw_decode u_decode (
        .req   (cpu_req),
        .we    (cpu_we),
        .addr  (cpu_addr),
        .bank0 (banks[0]),
        .dec   (dec)
    );

    cfw_bank_regs u_banks (
        .clk   (clk),
        .rst   (rst),
        .load  (dec.bank_load),
        .idx   (cpu_addr[12:11]),
        .wdata (cpu_wdata),
        .banks (banks)
    );

    assign start_xfer = dec.xfer && !busy;
    assign sel_go     = dec.sel_load && !busy;
    assign tx_byte    = cpu_we ? cpu_wdata : IDLE_BYTE;

    cfw_spi_shifter #(.HALF_DIV(HALF_DIV)) u_spi (
        .clk     (clk),
        .rst     (rst),
        .start   (start_xfer),
        .tx      (tx_byte),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .busy    (busy),
        .rx_byte (rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            card_sel   <= 1'b0;
            cs_level_q <= 1'b1;
        end else begin
            if (sel_go)     card_sel   <= cpu_wdata[0];
            if (start_xfer) cs_level_q <= dec.cs_level;
        end
    end

    for (genvar c = 0; c < NUM_CARDS; c++) begin : g_cs
        assign spi_cs_n[c] = (card_sel == 1'(c)) ? cs_level_q : 1'b1;
    end

    assign flash_hit   = dec.in_window && !dec.card_area;
    assign flash_addr  = map_flash(banks[dec.page], cpu_addr);
    assign flash_we    = cpu_req && cpu_we && flash_hit;
    assign flash_re    = cpu_req && !cpu_we && flash_hit;
    assign flash_wdata = cpu_wdata;

    always_comb begin
        if (!dec.in_window)    cpu_rdata = IDLE_BYTE;
        else if (dec.card_area) cpu_rdata = rx_byte;
        else                    cpu_rdata = flash_rdata;
    end

    // R11
    cs_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(spi_cs_n) >= 1);
    // R6
    cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(spi_cs_n));
    // R4
    unmapped_ff_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_we && (cpu_addr < 16'h4000 || cpu_addr >= 16'hC000))
            |-> (cpu_rdata == 8'hFF && !flash_re));
    // R5
    card_no_flash_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && banks[0][7:6] == 2'b01 && cpu_addr[15:13] == 3'b010)
            |-> (!flash_we && !flash_re));
endmodule

// File: tb/card_flash_window_bench.sv
module card_flash_window_bench;
    localparam int H = 2;
    localparam int XFER = 16 * H;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [22:0] flash_addr;
    logic        flash_we, flash_re;
    logic [7:0]  flash_wdata, flash_rdata;
    logic        spi_sclk, spi_mosi, spi_miso = 1'b1;
    logic [1:0]  spi_cs_n;
    logic        busy;

    int compared = 0, mismatched = 0, cycles = 0;
    logic done = 1'b0;

    // reference model state
    logic [7:0] m_bank [4];
    logic       m_sel, m_cs;
    logic [7:0] m_tx, m_rx, m_slave, slave_tx;
    int         m_cnt;

    always #4 clk = ~clk;

    assign flash_rdata = flash_addr[7:0] ^ flash_addr[20:13];

    card_flash_window #(.HALF_DIV(H)) u_card_flash_window (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .flash_addr(flash_addr), .flash_we(flash_we), .flash_re(flash_re),
        .flash_wdata(flash_wdata), .flash_rdata(flash_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n), .busy(busy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
        end
    endtask

    function automatic logic card_area(input logic [15:0] a);
        return (m_bank[0][7:6] == 2'b01) && (a >= 16'h4000) && (a < 16'h6000);
    endfunction

    // model update on every clock
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_bank[0] = 8'h00; m_bank[1] = 8'h01; m_bank[2] = 8'h00; m_bank[3] = 8'h00;
            m_sel = 1'b0; m_cs = 1'b1; m_tx = 8'hFF; m_rx = 8'hFF; m_slave = 8'hFF; m_cnt = 0;
        end else begin
            logic was_busy;
            was_busy = (m_cnt > 0);
            if (was_busy) begin
                m_cnt--;
                if (m_cnt == 0) m_rx = m_slave;
            end
            if (cpu_req) begin
                if (card_area(cpu_addr)) begin
                    if (!was_busy) begin
                        if (cpu_we && cpu_addr >= 16'h5800) m_sel = cpu_wdata[0];
                        else begin
                            m_cs = cpu_addr[12];
                            m_tx = cpu_we ? cpu_wdata : 8'hFF;
                            m_slave = slave_tx;
                            m_cnt = XFER;
                        end
                    end
                end else if (cpu_we && cpu_addr >= 16'h6000 && cpu_addr < 16'h8000) begin
                    m_bank[cpu_addr[12:11]] = cpu_wdata;
                end
            end
        end
        if (cycles > 150000 && !done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // drive MISO from the slave byte, compare all outputs mid-cycle
    always @(negedge clk) begin
        int t;
        logic inw, card;
        logic [22:0] ea;
        t = XFER - m_cnt;
        spi_miso = (m_cnt > 0) ? m_slave[7 - t / (2 * H)] : 1'b1;
        #2;
        if (!rst) begin
            inw  = (cpu_addr >= 16'h4000) && (cpu_addr < 16'hC000);
            card = card_area(cpu_addr);
            ea   = 23'h700000 + 23'({m_bank[(cpu_addr - 16'h4000) >> 13][6:0], 13'h0})
                   + 23'(cpu_addr[12:0]);
            check("R8 busy", busy, m_cnt > 0);
            check("R8 sclk", spi_sclk, (m_cnt > 0) && ((t / H) % 2 == 1));
            check("R8 mosi", spi_mosi, (m_cnt > 0) ? m_tx[7 - t / (2 * H)] : 1'b1);
            check("R6 cs_n card0", spi_cs_n[0], m_sel ? 1'b1 : m_cs);
            check("R11 cs_n card1", spi_cs_n[1], m_sel ? m_cs : 1'b1);
            check("R3 flash_we", flash_we, cpu_req && cpu_we && inw && !card);
            check("R5 flash_re", flash_re, cpu_req && !cpu_we && inw && !card);
            if (cpu_req && inw && !card) begin
                check("R3 flash_addr", flash_addr, ea);
                if (cpu_we) check("R3 flash_wdata", flash_wdata, cpu_wdata);
            end
            if (!inw)      check("R4 rdata", cpu_rdata, 8'hFF);
            else if (card) check("R9 rdata", cpu_rdata, m_rx);
            else           check("R3 rdata", cpu_rdata, ea[7:0] ^ ea[20:13]);
        end
    end

    task automatic access(input logic we, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_cnt > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        slave_tx = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #3;
        // R1 reset state at the ports
        check("R1 cs_n", spi_cs_n, 2'b11);
        check("R1 busy", busy, 1'b0);
        check("R1 sclk", spi_sclk, 1'b0);
        check("R1 mosi", spi_mosi, 1'b1);
        // R1 reset banks, seen through R3 mapping
        access(0, 16'h4000, 0); access(0, 16'h6123, 0);
        access(0, 16'h8000, 0); access(0, 16'hA000, 0);
        // R4 outside the window
        access(0, 16'h0000, 0); access(0, 16'h3FFF, 0);
        access(0, 16'hC000, 0); access(0, 16'hFFFF, 0);
        // R2 bank loads, flash write uses old bank
        access(1, 16'h6000, 8'h05); access(1, 16'h6800, 8'h83);
        access(1, 16'h7000, 8'h7F); access(1, 16'h7FFF, 8'hAA);
        access(1, 16'h6000, 8'h12);
        access(0, 16'h4ABC, 0); access(0, 16'h7001, 0);
        access(0, 16'h9FFF, 0); access(0, 16'hBFFE, 0);
        access(1, 16'h8800, 8'h3C); access(1, 16'hA000, 8'h11);
        // R5 card area on
        access(1, 16'h6000, 8'h40);
        slave_tx = 8'h3C;
        access(1, 16'h4000, 8'hA5);       // R6 cs low, R8 write byte
        access(1, 16'h5800, 8'h01);       // R10 ignored while busy
        access(1, 16'h4100, 8'h11);       // R10 ignored while busy
        access(0, 16'h4200, 0);           // R10 read while busy
        wait_idle();
        slave_tx = 8'hC3;
        access(0, 16'h4000, 0);           // R9 returns 3C, sends FF
        wait_idle();
        slave_tx = 8'h5A;
        access(0, 16'h4800, 0);
        wait_idle();
        slave_tx = 8'h81;
        access(1, 16'h5000, 8'h00);       // R6 cs high
        wait_idle();
        access(1, 16'h5800, 8'h01);       // R7 select card 1
        slave_tx = 8'h6E;
        access(1, 16'h4000, 8'h96);       // R11 card1 low, card0 high
        wait_idle();
        access(1, 16'h5FFF, 8'h00);       // R7 back to card 0, level follows
        @(negedge clk); #3;
        check("R7 cs_n after select", spi_cs_n, 2'b10);
        slave_tx = 8'h24;
        access(0, 16'h5900, 0);           // R6 read in select range: cs high
        wait_idle();
        access(0, 16'h4000, 0);
        wait_idle();
        access(1, 16'hA000, 8'h77);       // flash still reachable
        access(1, 16'h6000, 8'h00);       // R5 card area off
        access(0, 16'h4000, 0); access(1, 16'h5000, 8'h99);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule